// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port that lets a host processor read and write a small register file over a four-line serial link. The link has a chip-select (active low), a serial clock, a data line into the block and a data line out of it. Every access is a single frame of exactly sixteen serial-clock rising edges while chip-select is low. The frame carries a three-bit command, then a five-bit register address with its least significant bit first, then eight data bits with their least significant bit first.

The port runs on the chip's own system clock. It passes the three serial inputs through synchronizers and finds the serial-clock and chip-select edges by oversampling them. A write reaches the register file as a one-cycle strobe carrying address and data. The strobe is issued only after chip-select returns high, and only for a complete, well-formed frame. A read fetches the addressed register from the read-data bus once the address is complete. The port then shifts the value out, least significant bit first, and raises an output-enable only while those data bits are on the line. The data-out pad can be joined to the data-in pad to give a three-wire link.

Top module: `cport_ctrl_slave`

## Requirements
- R1: While reset is held and right after it is released, `sdo_oe` and `reg_wr` are both 0.
- R2: A frame whose command bits arrive as 1,1,1, with an address of 13 or less and exactly 16 rising edges, produces exactly one `reg_wr` pulse of one cycle. The pulse comes after chip-select has risen, never while chip-select is low. It carries `reg_addr` = the five address bits and `reg_wdata` = the eight data bits, each reassembled with the first-received bit as bit 0.
- R3: A frame whose first or second command bit is 0 writes nothing and never raises `sdo_oe`.
- R4: A frame addressing 14 to 31 writes nothing. A read of such an address leaves `sdo_oe` at 0 for the whole frame.
- R5: A write frame with 15 or with 17 rising edges before chip-select rises is dropped, with no `reg_wr` pulse and no change to the register file.
- R6: A frame whose command bits arrive as 1,1,0, with an address of 13 or less, returns the addressed register on `sdo` over the eight data-bit times, least significant bit first. Each bit changes after a falling serial-clock edge and is stable at the following rising edge.
- R7: `sdo_oe` is 1 only during the eight data-bit times of a valid read frame. It is 0 during the command and address bits, during any write frame, and while chip-select is high.
- R8: With data-out fed back onto data-in whenever `sdo_oe` is 1 (three-wire use), a read returns the same value as in four-wire use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low, high when idle |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host, sampled on rising `sclk` |
| reg_rdata | input | 8 | Register file read data for address `reg_addr` |
| sdo | output | 1 | Serial read data, changes after falling `sclk` |
| sdo_oe | output | 1 | Enable for the external tri-state driver of `sdo` |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Register address for writes and reads |
| reg_wdata | output | 8 | Register write data, valid with `reg_wr` |

## Verification
The properties assume that the serial clock and chip-select are much slower than the system clock, so that each serial level is held for several system cycles after it passes the synchronizer. Under that assumption every serial edge appears as a single, separate event. They also assume that chip-select only moves while the serial clock is high. The stimulus holds every serial level for eight system cycles and changes data only while the serial clock is low. It drops and raises chip-select only with the serial clock high, and waits between frames. This keeps the strobe, output-enable and shift timing within those assumptions.

// File: rtl/cport_pkg.sv
package cport_pkg;

    localparam int OP_W      = 3;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = OP_W + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t OP_END    = cnt_t'(OP_W);
    localparam cnt_t ADDR_END  = cnt_t'(OP_W + ADDR_W);
    localparam cnt_t FRAME_CNT = cnt_t'(FRAME_LEN);
    localparam cnt_t CNT_MAX   = cnt_t'(FRAME_LEN + 1);

    // command bits indexed in arrival order (bit 0 arrives first)
    localparam logic [OP_W-1:0] OP_WR = 3'b111;
    localparam logic [OP_W-1:0] OP_RD = 3'b011;

    typedef struct packed {
        cnt_t              cnt;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr_stb;
        logic              ld;
        logic              ld_done;
        logic              cs_prev;
        logic              sclk_prev;
    } frame_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              sdo;
        logic              oe;
    } tx_st_t;

endpackage

// File: rtl/cport_sync.sv
module cport_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cport_frame.sv
module cport_frame
    import cport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LAST_ADDR = 5'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    input  logic              sdi_lvl,
    output logic              cs_rise,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [OP_W-1:0]   op,
    output logic              ld,
    output logic              drive_win
);
    frame_st_t st_d, st_q;
    logic addr_ok, rd_ok;

    assign cs_rise   = cs_lvl & ~st_q.cs_prev;
    assign sclk_rise = sclk_lvl & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_lvl & st_q.sclk_prev;
    assign addr_ok   = (st_q.addr <= LAST_ADDR);
    assign rd_ok     = (st_q.op == OP_RD) && addr_ok && (st_q.cnt >= ADDR_END);
    assign drive_win = ~cs_lvl && rd_ok && (st_q.cnt < FRAME_CNT);

    always_comb begin
        st_d           = st_q;
        st_d.wr_stb    = 1'b0;
        st_d.ld        = 1'b0;
        st_d.cs_prev   = cs_lvl;
        st_d.sclk_prev = sclk_lvl;
        if (cs_lvl) begin
            st_d.cnt     = '0;
            st_d.ld_done = 1'b0;
            if (cs_rise && st_q.cnt == FRAME_CNT && st_q.op == OP_WR && addr_ok) begin
                st_d.wr_stb = 1'b1;
            end
        end else begin
            if (sclk_rise) begin
                if (st_q.cnt < OP_END) begin
                    st_d.op = {sdi_lvl, st_q.op[OP_W-1:1]};
                end else if (st_q.cnt < ADDR_END) begin
                    st_d.addr = {sdi_lvl, st_q.addr[ADDR_W-1:1]};
                end else if (st_q.cnt < FRAME_CNT) begin
                    st_d.data = {sdi_lvl, st_q.data[DATA_W-1:1]};
                end
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + cnt_t'(1);
            end
            if (rd_ok && !st_q.ld_done) begin
                st_d.ld      = 1'b1;
                st_d.ld_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_stb = st_q.wr_stb;
    assign addr   = st_q.addr;
    assign wdata  = st_q.data;
    assign op     = st_q.op;
    assign ld     = st_q.ld;
endmodule

// File: rtl/cport_txd.sv
module cport_txd
    import cport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_fall,
    input  logic              ld,
    input  logic              drive_win,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              sdo_oe
);
    tx_st_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (ld) tx_d.sh = rdata;
        if (cs_lvl) begin
            tx_d.oe = 1'b0;
        end else if (sclk_fall) begin
            if (drive_win) begin
                tx_d.sdo = tx_q.sh[0];
                tx_d.sh  = {1'b0, tx_q.sh[DATA_W-1:1]};
                tx_d.oe  = 1'b1;
            end else begin
                tx_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sdo    = tx_q.sdo;
    assign sdo_oe = tx_q.oe;
endmodule

// File: rtl/cport_ctrl_slave.sv
module cport_ctrl_slave
    import cport_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] LAST_ADDR   = 5'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int          N_IN     = 3;
    localparam logic [N_IN-1:0] IDLE_LVL = 3'b011; // {sdi, sclk, cs_n}

    logic [N_IN-1:0] raw_in, lvl;
    logic cs_lvl, sclk_lvl, sdi_lvl;
    logic cs_rise, sclk_rise, sclk_fall;
    logic ld, drive_win;
    logic [OP_W-1:0] op_q;

    assign raw_in = {sdi, sclk, cs_n};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        cport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL[gi])) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[gi]),
            .dout (lvl[gi])
        );
    end

    assign cs_lvl   = lvl[0];
    assign sclk_lvl = lvl[1];
    assign sdi_lvl  = lvl[2];

    cport_frame #(.LAST_ADDR(LAST_ADDR)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (cs_lvl),
        .sclk_lvl (sclk_lvl),
        .sdi_lvl  (sdi_lvl),
        .cs_rise  (cs_rise),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .wr_stb   (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .op       (op_q),
        .ld       (ld),
        .drive_win(drive_win)
    );

    cport_txd txd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (cs_lvl),
        .sclk_fall(sclk_fall),
        .ld       (ld),
        .drive_win(drive_win),
        .rdata    (reg_rdata),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );
endmodule

// File: rtl/cport_ctrl_slave_chk.sv
module cport_ctrl_slave_chk
    import cport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LAST_ADDR = 5'd13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_lvl,
    input logic              cs_rise,
    input logic              sclk_fall,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [OP_W-1:0]   op_q
);
    a_r2_wr_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(cs_rise));

    a_r2_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    a_r4_wr_addr_limit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_addr <= LAST_ADDR);

    a_r6_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sclk_fall));

    a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sclk_fall));

    a_r7_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !sdo_oe);

    a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> op_q == OP_RD);
endmodule

bind cport_ctrl_slave cport_ctrl_slave_chk #(.LAST_ADDR(LAST_ADDR)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_lvl),
    .cs_rise  (cs_rise),
    .sclk_fall(sclk_fall),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .op_q     (op_q)
);

// File: tb/cport_ctrl_slave_tb.sv
`timescale 1ns/1ps
module cport_ctrl_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       host_sdi = 1'b0;
    logic       tie3 = 1'b0;
    logic       sdi_w;
    logic [7:0] reg_rdata;
    logic       sdo, sdo_oe, reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_tag = "R2";

    logic [7:0]  rf     [0:15];
    logic [7:0]  exp_rf [0:15];
    logic [12:0] exp_q  [$];

    always #4 clk = ~clk;

    assign sdi_w     = (tie3 && sdo_oe) ? sdo : host_sdi;
    assign reg_rdata = (reg_addr < 5'd14) ? rf[reg_addr[3:0]] : 8'hEE;

    cport_ctrl_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi_w),
        .reg_rdata(reg_rdata), .sdo(sdo), .sdo_oe(sdo_oe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    // register file model on the bench side
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rf[i] <= 8'(i * 17 + 3);
        end else if (reg_wr && reg_addr < 5'd14) begin
            rf[reg_addr[3:0]] <= reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for write strobes
    always @(negedge clk) begin
        if (rst_n && reg_wr && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected write"}, {19'd0, reg_addr, reg_wdata}, 32'd0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R2 write addr/data", {19'd0, reg_addr, reg_wdata}, {19'd0, e});
                chk(cs_n == 1'b1, "R2 strobe after cs high", {31'd0, cs_n}, 32'd1);
            end
        end
    end

    task automatic run_frame(input logic [2:0] opb, input logic [4:0] a, input logic [7:0] d,
                             input int nedge, input bit tie,
                             output logic [15:0] so, output logic [15:0] oe);
        logic [15:0] fr;
        fr = {d, a, opb};
        so = '0;
        oe = '0;
        tie3 = tie;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < nedge; k++) begin
            sclk = 1'b0;
            host_sdi = (k < 16) ? fr[k] : 1'b0;
            repeat (8) @(negedge clk);
            if (k < 16) begin
                so[k] = sdo;
                oe[k] = sdo_oe;
            end
            sclk = 1'b1;
            repeat (8) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        tie3 = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] opb, input logic [4:0] a, input logic [7:0] d,
                            input int nedge, input string tag);
        logic [15:0] so, oe;
        cur_tag = tag;
        if (opb == 3'b111 && nedge == 16 && a <= 5'd13) begin
            exp_q.push_back({a, d});
            exp_rf[a[3:0]] = d;
        end
        run_frame(opb, a, d, nedge, 1'b0, so, oe);
        chk(oe == 16'h0, "R7 no drive on write frame", {16'd0, oe}, 32'd0);
        chk(exp_q.size() == 0, {tag, " strobe count"}, exp_q.size(), 32'd0);
    endtask

    task automatic do_read(input logic [4:0] a, input bit tie, input string tag);
        logic [15:0] so, oe;
        cur_tag = tag;
        run_frame(3'b011, a, 8'h00, 16, tie, so, oe);
        if (a <= 5'd13) begin
            chk(oe == 16'hFF00, {tag, " R7 oe window"}, {16'd0, oe}, 32'hFF00);
            chk(so[15:8] == exp_rf[a[3:0]], {tag, " read data"}, {24'd0, so[15:8]}, {24'd0, exp_rf[a[3:0]]});
        end else begin
            chk(oe == 16'h0, {tag, " R4 no drive"}, {16'd0, oe}, 32'd0);
        end
        chk(sdo_oe == 1'b0, "R7 oe low after cs", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_rf[i] = 8'(i * 17 + 3);
        repeat (5) @(negedge clk);
        chk(sdo_oe == 1'b0 && reg_wr == 1'b0, "R1 quiet in reset", {30'd0, sdo_oe, reg_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1'b0 && reg_wr == 1'b0, "R1 quiet after reset", {30'd0, sdo_oe, reg_wr}, 32'd0);

        do_write(3'b111, 5'd5, 8'hA6, 16, "R2");
        do_write(3'b111, 5'd13, 8'h3C, 16, "R2");
        do_read(5'd5, 1'b0, "R6");
        do_read(5'd13, 1'b0, "R6");
        do_read(5'd0, 1'b0, "R6");

        do_write(3'b101, 5'd5, 8'h11, 16, "R3");
        do_write(3'b110, 5'd5, 8'h22, 16, "R3");
        do_read(5'd5, 1'b0, "R3");

        do_write(3'b111, 5'd14, 8'h55, 16, "R4");
        do_write(3'b111, 5'd31, 8'h66, 16, "R4");
        do_read(5'd14, 1'b0, "R4");
        do_read(5'd31, 1'b0, "R4");

        do_write(3'b111, 5'd5, 8'h77, 15, "R5");
        do_write(3'b111, 5'd5, 8'h88, 17, "R5");
        do_read(5'd5, 1'b0, "R5");

        do_write(3'b111, 5'd2, 8'h81, 16, "R2");
        do_read(5'd2, 1'b1, "R8");
        do_read(5'd13, 1'b1, "R8");

        chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule